// File: doc/BRIEF.md
# Lockable Watchdog Timer with Prescaler

This block is a supervision timer. A 16-bit counter counts down once per prescaled slow tick. Software must keep writing a fixed key to a refresh register before the count runs out. The slow clock is delivered as a one-cycle tick enable in the bus clock domain. A two-bit field divides that tick by 1, 16, 256 or 4096 before it reaches the counter.

The timer leaves reset running with a default configuration, so early code must either service it or switch it off. While the configuration is still open, software may stop the timer, change the reload value, the divider and the timeout action, and start it again. Writing the control register with the enable bit set freezes the control and reload registers until the next reset. On expiry the block either raises a sticky reset request, or, in debug mode, gives a two-cycle interrupt pulse and starts a new period.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, CTRL (address 2) reads 0x0028 (enable bit 5 = 1, divider field bits [3:2] = 2, action bit 6 = 0), LOAD (address 0) and VALUE (address 1) read 0x1000, STATUS (address 3) reads 0, and both rst_req and irq are low. Read data appears on bus_rdata one cycle after the read request.
- R2: The divider field in bits [3:2] of CTRL selects the divide ratio: 0 gives 1, 1 gives 16, 2 gives 256 and 3 gives 4096. While enabled, the counter drops by one after each group of that many slow ticks.
- R3: An expiry happens when an enabled decrement step finds the counter at 1 or 0.
- R4: Writing 0xCCCC to REFRESH (address 4) reloads the counter from LOAD and clears the prescaler. Any other value written there changes neither the counter nor the prescaler.
- R5: A CTRL write with bit 5 set locks the configuration. After that, writes to CTRL and LOAD are ignored until reset, STATUS bit 4 reads 1, and the timer keeps running.
- R6: While unlocked, a CTRL write with bit 5 clear stops the counter, which then holds its value through slow ticks. A LOAD write is accepted but takes effect only at the next reload. Every accepted CTRL write reloads the counter from LOAD and clears the prescaler.
- R7: With bit 6 of CTRL at 0, an expiry leaves the counter at 0 and sets rst_req, which stays high until reset even if a refresh follows.
- R8: With bit 6 of CTRL at 1, an expiry reloads the counter from LOAD and counting continues. irq and STATUS bit 0 are high for exactly two cycles after the expiry, and rst_req stays low.
- R9: VALUE is read-only. Writing to it leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable from the slow time base |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| rst_req | output | 1 | Sticky system reset request |
| irq | output | 1 | Two-cycle timeout interrupt |

## Verification
The bench places its samples at the edges of the prescaler period. It gives the divide-by-16 setting 15 ticks and then one more. A divider that is off by one would decrement early or late there. A wrong refresh key is sent partway through a prescaler period. A design that clears the prescaler on any refresh write would then miss the expected decrement. A design that fails to clear it on the real key would decrement before a full period has passed. The lock test writes both guarded registers after locking and reads them back, so a lock that guards only one of them is caught. The interrupt test samples irq on three consecutive cycles and reads STATUS while the pulse is high. A pulse that is one cycle long or three cycles long is detected, and so is a design that raises rst_req in debug mode.

// File: rtl/svc_wd_pkg.sv
`timescale 1ns/1ps
package svc_wd_pkg;
  // bit positions inside the control and status words
  localparam int EN_BIT      = 5;
  localparam int MODE_BIT    = 6;
  localparam int SEL_LSB     = 2;
  localparam int ST_LOCK_BIT = 4;
  localparam int ST_IRQ_BIT  = 0;

  typedef struct packed {
    logic       mode;  // 1 = interrupt on expiry, 0 = reset request
    logic       en;
    logic [1:0] sel;   // divider select
  } wd_ctrl_t;
endpackage

// File: rtl/svc_wd_prescale.sv
`timescale 1ns/1ps
module svc_wd_prescale #(
  parameter int PRE_W     = 12,
  parameter int STEP_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       run,
  input  logic       clear,
  input  logic [1:0] sel,
  output logic       step
);
  localparam int NSEL = 4;

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] lim [NSEL];
  logic             at_lim;

  // limit for each select value is 2^(g*STEP_LOG2) - 1
  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim[g] = {PRE_W{1'b1}} >> (PRE_W - g * STEP_LOG2);
  end

  assign at_lim = (pcnt == lim[sel]);
  assign step   = tick & run & at_lim;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pcnt <= '0;
    end else if (tick && run) begin
      pcnt <= at_lim ? '0 : pcnt + 1'b1;
    end
  end

  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (rst)
    pcnt <= lim[sel]);  // R2
  AST_PRESC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick && !clear |=> $stable(pcnt));  // R2
endmodule

// File: rtl/svc_wd_counter.sv
`timescale 1ns/1ps
module svc_wd_counter #(
  parameter int          W       = 16,
  parameter logic [15:0] RST_VAL = 16'h1000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         reload,
  input  logic         halt,
  input  logic         irq_mode,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         expire
);
  logic live;

  assign live   = step & ~halt;
  assign expire = live & ~reload & (cnt <= W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= W'(RST_VAL);
    end else if (reload) begin
      cnt <= load_val;
    end else if (live) begin
      if (expire) cnt <= irq_mode ? load_val : '0;
      else        cnt <= cnt - 1'b1;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step && !reload |=> $stable(cnt));  // R6
  AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    expire && irq_mode |=> cnt == $past(load_val));  // R8
  AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (rst)
    expire && !irq_mode |=> cnt == '0);  // R7
endmodule

// File: rtl/svc_wd_action.sv
`timescale 1ns/1ps
module svc_wd_action #(
  parameter int IRQ_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic irq_mode,
  output logic rst_req,
  output logic irq
);
  localparam int LW = $clog2(IRQ_LEN + 1);

  logic [LW-1:0] irq_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
    end else if (expire && !irq_mode) begin
      rst_req <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_left <= '0;
    end else if (expire && irq_mode) begin
      irq_left <= LW'(IRQ_LEN);
    end else if (irq_left != '0) begin
      irq_left <= irq_left - 1'b1;
    end
  end

  assign irq = (irq_left != '0);

  AST_RSTREQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> rst_req);  // R7
  AST_RSTREQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> $past(expire && !irq_mode));  // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(expire && irq_mode));  // R8
endmodule

// File: rtl/svc_wd_regs.sv
`timescale 1ns/1ps
module svc_wd_regs
  import svc_wd_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          ADDR_W   = 3,
  parameter logic [15:0] KEY      = 16'hCCCC,
  parameter logic [15:0] LOAD_RST = 16'h1000,
  parameter logic [1:0]  SEL_RST  = 2'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     cnt,
  input  logic              irq,
  output logic [DW-1:0]     bus_rdata,
  output wd_ctrl_t          ctrl,
  output logic [DW-1:0]     load_val,
  output logic              locked,
  output logic              reload
);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_VALUE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(3);

  logic          wr_any, wr_ctrl, wr_load, kick;
  logic [DW-1:0] ctrl_word, stat_word;

  assign wr_any  = bus_sel & bus_wr;
  assign wr_ctrl = wr_any & (bus_addr == A_CTRL) & ~locked;
  assign wr_load = wr_any & (bus_addr == A_LOAD) & ~locked;
  assign kick    = wr_any & (bus_addr == ADDR_W'(4)) & (bus_wdata == DW'(KEY));
  assign reload  = wr_ctrl | kick;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl.en   <= 1'b1;
      ctrl.mode <= 1'b0;
      ctrl.sel  <= SEL_RST;
    end else if (wr_ctrl) begin
      ctrl.en   <= bus_wdata[EN_BIT];
      ctrl.mode <= bus_wdata[MODE_BIT];
      ctrl.sel  <= bus_wdata[SEL_LSB +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
    end else if (wr_ctrl && bus_wdata[EN_BIT]) begin
      locked <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_val <= DW'(LOAD_RST);
    end else if (wr_load) begin
      load_val <= bus_wdata;
    end
  end

  always_comb begin
    ctrl_word                  = '0;
    ctrl_word[EN_BIT]          = ctrl.en;
    ctrl_word[MODE_BIT]        = ctrl.mode;
    ctrl_word[SEL_LSB +: 2]    = ctrl.sel;
    stat_word                  = '0;
    stat_word[ST_LOCK_BIT]     = locked;
    stat_word[ST_IRQ_BIT]      = irq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_LOAD:  bus_rdata <= load_val;
        A_VALUE: bus_rdata <= cnt;
        A_CTRL:  bus_rdata <= ctrl_word;
        A_STAT:  bus_rdata <= stat_word;
        default: bus_rdata <= '0;
      endcase
    end
  end

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);  // R5
  AST_LOCK_ENABLED: assert property (@(posedge clk) disable iff (rst)
    locked |-> ctrl.en);  // R5
  AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (rst)
    locked && bus_sel && bus_wr |=> $stable(load_val) && $stable(ctrl));  // R5
endmodule

// File: rtl/svc_watchdog.sv
`timescale 1ns/1ps
module svc_watchdog
  import svc_wd_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int          ADDR_W    = 3,
  parameter int          PRE_W     = 12,
  parameter int          STEP_LOG2 = 4,
  parameter int          IRQ_LEN   = 2,
  parameter logic [15:0] KEY       = 16'hCCCC,
  parameter logic [15:0] LOAD_RST  = 16'h1000,
  parameter logic [1:0]  SEL_RST   = 2'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              rst_req,
  output logic              irq
);
  wd_ctrl_t      ctrl;
  logic [DW-1:0] load_val, cnt;
  logic          locked, reload, step, expire;

  svc_wd_regs #(
    .DW(DW), .ADDR_W(ADDR_W), .KEY(KEY), .LOAD_RST(LOAD_RST), .SEL_RST(SEL_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt), .irq(irq),
    .bus_rdata(bus_rdata), .ctrl(ctrl), .load_val(load_val),
    .locked(locked), .reload(reload)
  );

  svc_wd_prescale #(.PRE_W(PRE_W), .STEP_LOG2(STEP_LOG2)) u_pre (
    .clk(clk), .rst(rst), .tick(slow_tick), .run(ctrl.en),
    .clear(reload), .sel(ctrl.sel), .step(step)
  );

  svc_wd_counter #(.W(DW), .RST_VAL(LOAD_RST)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .reload(reload), .halt(rst_req),
    .irq_mode(ctrl.mode), .load_val(load_val), .cnt(cnt), .expire(expire)
  );

  svc_wd_action #(.IRQ_LEN(IRQ_LEN)) u_act (
    .clk(clk), .rst(rst), .expire(expire), .irq_mode(ctrl.mode),
    .rst_req(rst_req), .irq(irq)
  );

  AST_NO_RST_IN_DEBUG: assert property (@(posedge clk) disable iff (rst)
    ctrl.mode && !rst_req |=> !rst_req);  // R8
endmodule

// File: tb/svc_watchdog_test.sv
`timescale 1ns/1ps
module svc_watchdog_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rst_req, irq;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [2:0] A_LOAD = 3'd0, A_VALUE = 3'd1, A_CTRL = 3'd2,
                         A_STAT = 3'd3, A_KICK = 3'd4;

  always #2.5 clk = ~clk;

  svc_watchdog uut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; slow_tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic ticks(input int n);
    slow_tick = 1'b1;
    repeat (n) @(negedge clk);
    slow_tick = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // configure while open, then lock with the given control word
  task automatic setup_locked(input logic [15:0] ld, input logic [15:0] cw);
    wr(A_CTRL, 16'h0000);
    wr(A_LOAD, ld);
    wr(A_CTRL, cw);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_reset();
    rd(A_CTRL, d);  check("R1 ctrl", d, 16'h0028);
    rd(A_LOAD, d);  check("R1 load", d, 16'h1000);
    rd(A_VALUE, d); check("R1 value", d, 16'h1000);
    rd(A_STAT, d);  check("R1 status", d, 16'h0000);
    check("R1 rst_req", {15'd0, rst_req}, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);
    ticks(256);
    rd(A_VALUE, d); check("R2 default div256", d, 16'h0FFF);
  endtask

  task automatic t_prescale();
    logic [15:0] d;
    do_reset(); setup_locked(16'd100, 16'h0020);
    ticks(5); rd(A_VALUE, d); check("R2 div1", d, 16'd95);
    do_reset(); setup_locked(16'd100, 16'h0024);
    ticks(48); rd(A_VALUE, d); check("R2 div16 three steps", d, 16'd97);
    ticks(15); rd(A_VALUE, d); check("R2 div16 short of step", d, 16'd97);
    ticks(1);  rd(A_VALUE, d); check("R2 div16 step edge", d, 16'd96);
    do_reset(); setup_locked(16'd100, 16'h0028);
    ticks(512); rd(A_VALUE, d); check("R2 div256", d, 16'd98);
    do_reset(); setup_locked(16'd100, 16'h002C);
    ticks(4095); rd(A_VALUE, d); check("R2 div4096 short", d, 16'd100);
    ticks(1);    rd(A_VALUE, d); check("R2 div4096 step", d, 16'd99);
  endtask

  task automatic t_refresh();
    logic [15:0] d;
    do_reset(); setup_locked(16'd50, 16'h0024);
    ticks(10);
    wr(A_KICK, 16'h1234);
    ticks(6); rd(A_VALUE, d); check("R4 wrong key ignored", d, 16'd49);
    wr(A_KICK, 16'hCCCC);
    rd(A_VALUE, d); check("R4 key reloads", d, 16'd50);
    ticks(15); rd(A_VALUE, d); check("R4 prescaler cleared", d, 16'd50);
    ticks(1);  rd(A_VALUE, d); check("R4 full period after key", d, 16'd49);
  endtask

  task automatic t_lock();
    logic [15:0] d;
    do_reset();
    wr(A_CTRL, 16'h0000); wr(A_LOAD, 16'd20);
    rd(A_STAT, d); check("R5 open status", d, 16'h0000);
    wr(A_CTRL, 16'h0020);
    rd(A_STAT, d); check("R5 lock flag", d, 16'h0010);
    wr(A_CTRL, 16'h0000); wr(A_LOAD, 16'h0777);
    rd(A_CTRL, d); check("R5 ctrl frozen", d, 16'h0020);
    rd(A_LOAD, d); check("R5 load frozen", d, 16'd20);
    ticks(3); rd(A_VALUE, d); check("R5 still running", d, 16'd17);
  endtask

  task automatic t_open();
    logic [15:0] d;
    do_reset();
    wr(A_CTRL, 16'h0000);
    rd(A_CTRL, d); check("R6 disabled ctrl", d, 16'h0000);
    rd(A_STAT, d); check("R6 not locked", d, 16'h0000);
    ticks(600); rd(A_VALUE, d); check("R6 holds when off", d, 16'h1000);
    wr(A_LOAD, 16'h0030);
    rd(A_LOAD, d); check("R6 load accepted", d, 16'h0030);
    rd(A_VALUE, d); check("R6 load deferred", d, 16'h1000);
    wr(A_CTRL, 16'h0000);
    rd(A_VALUE, d); check("R6 ctrl write reloads", d, 16'h0030);
    wr(A_VALUE, 16'h0055);
    rd(A_VALUE, d); check("R9 value read-only", d, 16'h0030);
  endtask

  task automatic t_reset_mode();
    logic [15:0] d;
    do_reset(); setup_locked(16'd5, 16'h0020);
    ticks(4); rd(A_VALUE, d); check("R3 before expiry", d, 16'd1);
    check("R7 no request yet", {15'd0, rst_req}, 16'd0);
    ticks(1);
    check("R7 request raised", {15'd0, rst_req}, 16'd1);
    rd(A_VALUE, d); check("R7 counter at zero", d, 16'd0);
    ticks(10); rd(A_VALUE, d); check("R7 stays zero", d, 16'd0);
    wr(A_KICK, 16'hCCCC);
    check("R7 request sticky", {15'd0, rst_req}, 16'd1);
  endtask

  task automatic t_irq_mode();
    logic [15:0] d;
    do_reset(); setup_locked(16'd3, 16'h0060);
    ticks(2); rd(A_VALUE, d); check("R3 one left", d, 16'd1);
    check("R8 irq idle", {15'd0, irq}, 16'd0);
    ticks(1);
    check("R8 irq cycle 1", {15'd0, irq}, 16'd1);
    rd(A_STAT, d); check("R8 status flag", d, 16'h0011);
    check("R8 irq cycle 2", {15'd0, irq}, 16'd1);
    @(negedge clk);
    check("R8 irq ends", {15'd0, irq}, 16'd0);
    rd(A_VALUE, d); check("R8 reloaded", d, 16'd3);
    ticks(3);
    check("R8 second expiry", {15'd0, irq}, 16'd1);
    check("R8 no reset request", {15'd0, rst_req}, 16'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, got no end expected end");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_prescale();
    t_refresh();
    t_lock();
    t_open();
    t_reset_mode();
    t_irq_mode();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule